// File: doc/BRIEF.md
# Power-Fail Auto-Save Sequencer

This block watches a digital supply-low flag. When the supply drops, it starts one complete copy of the working RAM into the nonvolatile shadow array. Software must first arm it by setting an enable latch through the command decoder's set and clear pulses. If the latch is clear when the supply drops, nothing is saved for that whole event.

While a save is running, the block holds a host-inhibit line high so that no other access reaches the memory. It hands the copy itself to the store/recall controller through a request/done handshake. If the controller does not report completion, the block ends the save when a clock-counted budget runs out. Either way, it marks the end of the save with a one-cycle pulse.

A separate alert output follows the synchronized supply-low flag. It is the enable of an active-low, open-drain driver, so several devices can share one interrupt wire. A brownout input comes from the power-on-reset logic and marks the supply as below the reset level. It clears the enable latch, and the latch stays clear after the supply recovers.

Top module: `psave_seq`

## Requirements
- R1: When armed is 1 and supply_low rises, store_req and host_inhibit go to 1 on the third rising clock edge after supply_low is first sampled high (the flag passes through a two-flop synchronizer, SYNC_STAGES=2).
- R2: If armed is 0 when the synchronized flag first goes high, no save occurs during that supply-low event, even if arm_set arrives later in the same event.
- R3: alert_pull goes to 1 on the second edge after supply_low is sampled high and back to 0 on the second edge after it is sampled low, whatever the arm state and any save.
- R4: host_inhibit and store_req stay 1 from the start of a save until the save ends, and are 0 otherwise.
- R5: A save ends at the first edge where store_done is sampled 1 while saving. save_end is 1 for exactly the one cycle that follows that edge.
- R6: If store_done never arrives, the save is forced to end after exactly SAVE_BUDGET_CLKS cycles of host_inhibit, and save_end pulses as in R5.
- R7: Only one save is issued per supply-low event. Another save needs supply_low to fall and rise again.
- R8: arm_set sets armed at the next edge and arm_clr clears it. When both arrive in the same cycle, arm_clr wins.
- R9: While brownout is 1, armed is 0 at the following edge and arm_set is ignored. armed stays 0 after brownout ends until a new arm_set.
- R10: After reset, armed, store_req, host_inhibit, save_end and alert_pull are all 0.
- R11: store_done while no save is in progress has no effect: save_end stays 0 and no save starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_low | input | 1 | Supply below save threshold (asynchronous) |
| brownout | input | 1 | Supply below power-on-reset level (synchronous) |
| arm_set | input | 1 | Command decoder pulse: enable auto-save |
| arm_clr | input | 1 | Command decoder pulse: disable auto-save |
| store_done | input | 1 | Store controller reports copy finished |
| store_req | output | 1 | Request to store controller to copy RAM to shadow |
| host_inhibit | output | 1 | Block all other device functions |
| save_end | output | 1 | One-cycle pulse when a save ends |
| alert_pull | output | 1 | Enable of the open-drain active-low alert driver |
| armed | output | 1 | Auto-save enable latch |

## Verification
A table of supply-fail events is run through the block. The events vary the arm state and how many cycles the controller takes before reporting done: immediately, mid-budget, exactly at the budget, past the budget, and never. These runs separate a save ended by the handshake from one ended by the budget, and an armed event from an unarmed one. Directed sequences cover the remaining corners: the cycle in which the request and alert first appear, a long hold of the low flag with no second save, arming during an event that is already running, set and clear arriving together, a brownout that clears the latch, and a done pulse while idle.

// File: rtl/psave_pkg.sv
// Package: shared types for the power-fail auto-save sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package psave_pkg;

    // Sequencer states: waiting, saving, waiting for the low flag to clear
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SAVE = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;

endpackage

// File: rtl/psave_sync.sv
// Module: multi-flop synchronizer for one asynchronous level input.
// Assumes: input is a slow level; STAGES >= 1; output resets to 0.
module psave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single register stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_multi
            // Shift the input through the register chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/psave_arm_latch.sv
// Module: auto-save enable latch.
// Priority: brownout clear, then explicit clear, then set.
// Assumes: set/clear pulses and brownout are synchronous to clk.
module psave_arm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic brownout_i,
    output logic armed_o
);

    // Hold the enable bit, cleared by brownout or command
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_o <= 1'b0;
        else if (brownout_i) armed_o <= 1'b0;
        else if (clr_i)      armed_o <= 1'b0;
        else if (set_i)      armed_o <= 1'b1;
    end

    AST_BROWNOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        brownout_i |=> !armed_o); // R9
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !brownout_i) |=> !armed_o); // R8
    AST_SET_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && !brownout_i) |=> armed_o); // R8

endmodule

// File: rtl/psave_fsm.sv
// Module: save sequencer. It issues one store request per supply-low event
// when armed, ends the save on done or on budget expiry, and pulses end.
// Assumes: low_i is already synchronized; BUDGET >= 2.
module psave_fsm
    import psave_pkg::*;
#(
    parameter int BUDGET = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic armed_i,
    input  logic done_i,
    output logic req_o,
    output logic end_o
);

    localparam int CNT_W = $clog2(BUDGET);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUDGET - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             end_q;

    // State, budget counter and end pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            end_q <= 1'b0;
        end else begin
            end_q <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    cnt <= '0;
                    if (low_i) state <= armed_i ? SEQ_SAVE : SEQ_HOLD;
                end
                SEQ_SAVE: begin
                    if (done_i || cnt == LAST) begin
                        state <= SEQ_HOLD;
                        end_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    if (!low_i) state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign req_o = (state == SEQ_SAVE);
    assign end_o = end_q;

    AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(armed_i) && $past(low_i))); // R1
    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> !end_o); // R5
    AST_BUDGET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && cnt == LAST) |=> (!req_o && end_o)); // R6
    AST_ONE_PER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_HOLD && low_i) |=> !req_o); // R7
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && done_i) |=> !end_o); // R11

endmodule

// File: rtl/psave_seq.sv
// Module: top of the power-fail auto-save sequencer.
// Assumes: supply_low is asynchronous; every other input is synchronous to clk.
module psave_seq #(
    parameter int SYNC_STAGES      = 2,
    parameter int SAVE_BUDGET_CLKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic brownout,
    input  logic arm_set,
    input  logic arm_clr,
    input  logic store_done,
    output logic store_req,
    output logic host_inhibit,
    output logic save_end,
    output logic alert_pull,
    output logic armed
);

    logic low_s;
    logic req;

    psave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (supply_low),
        .q_o   (low_s)
    );

    psave_arm_latch u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (arm_set),
        .clr_i      (arm_clr),
        .brownout_i (brownout),
        .armed_o    (armed)
    );

    psave_fsm #(.BUDGET(SAVE_BUDGET_CLKS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .low_i   (low_s),
        .armed_i (armed),
        .done_i  (store_done),
        .req_o   (req),
        .end_o   (save_end)
    );

    assign store_req    = req;
    assign host_inhibit = req;
    assign alert_pull   = low_s;

    AST_INHIBIT_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !store_done && !save_end) |=> (host_inhibit || save_end)); // R4

endmodule

// File: tb/psave_seq_tb_top.sv
module psave_seq_tb_top;

    localparam int BUDGET = 16;
    localparam int NVEC   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0, brownout = 1'b0, arm_set = 1'b0, arm_clr = 1'b0, store_done = 1'b0;
    logic store_req, host_inhibit, save_end, alert_pull, armed;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    psave_seq #(.SYNC_STAGES(2), .SAVE_BUDGET_CLKS(BUDGET)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .brownout(brownout),
        .arm_set(arm_set), .arm_clr(arm_clr), .store_done(store_done),
        .store_req(store_req), .host_inhibit(host_inhibit), .save_end(save_end),
        .alert_pull(alert_pull), .armed(armed)
    );

    // Vector table: {arm before event, done delay in busy cycles (0 = never)}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1, 8'd1}, {1'b1, 8'd3}, {1'b1, 8'd7}, {1'b1, 8'd16},
        {1'b1, 8'd0}, {1'b1, 8'd40}, {1'b0, 8'd3}, {1'b0, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_event(input bit do_arm, input int dly);
        int busy_n = 0;
        int end_n  = 0;
        int exp_busy;
        if (do_arm) arm_set = 1'b1; else arm_clr = 1'b1;
        cyc(1);
        arm_set = 1'b0; arm_clr = 1'b0;
        supply_low = 1'b1;
        for (int i = 0; i < BUDGET + 8; i++) begin
            cyc(1);
            if (host_inhibit != store_req) busy_n = busy_n + 1000;
            if (host_inhibit) begin
                busy_n++;
                store_done = (busy_n == dly);
            end else begin
                store_done = 1'b0;
            end
            if (save_end) end_n++;
        end
        store_done = 1'b0;
        exp_busy = !do_arm ? 0 : ((dly == 0 || dly > BUDGET) ? BUDGET : dly);
        check("R4/R5/R6 busy cycles", busy_n, exp_busy);
        check("R5/R7 end pulses", end_n, do_arm ? 1 : 0);
        check("R3 alert during event", int'(alert_pull), 1);
        supply_low = 1'b0;
        cyc(3);
        check("R3 alert after release", int'(alert_pull), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        cyc(200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seen;
        cyc(3);
        // R10 reset state
        check("R10 armed", int'(armed), 0);
        check("R10 store_req", int'(store_req), 0);
        check("R10 host_inhibit", int'(host_inhibit), 0);
        check("R10 save_end", int'(save_end), 0);
        check("R10 alert_pull", int'(alert_pull), 0);
        rst_n = 1'b1;
        cyc(2);

        // Table walk
        for (int v = 0; v < NVEC; v++) run_event(VEC[v][8], int'(VEC[v][7:0]));

        // R1 / R3 / R5 / R7 timing
        arm_set = 1'b1; cyc(1); arm_set = 1'b0;
        check("R8 armed after set", int'(armed), 1);
        supply_low = 1'b1;
        cyc(1);
        check("R3 alert after 1 edge", int'(alert_pull), 0);
        cyc(1);
        check("R3 alert after 2 edges", int'(alert_pull), 1);
        check("R1 no request after 2 edges", int'(store_req), 0);
        cyc(1);
        check("R1 request after 3 edges", int'(store_req), 1);
        check("R4 inhibit with request", int'(host_inhibit), 1);
        store_done = 1'b1;
        cyc(1);
        store_done = 1'b0;
        check("R5 request dropped on done", int'(store_req), 0);
        check("R5 end pulse", int'(save_end), 1);
        cyc(1);
        check("R5 end pulse one cycle", int'(save_end), 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin cyc(1); if (host_inhibit) seen++; end
        check("R7 no second save while low", seen, 0);
        supply_low = 1'b0;
        cyc(1);
        check("R3 alert still high 1 edge after release", int'(alert_pull), 1);
        cyc(1);
        check("R3 alert low 2 edges after release", int'(alert_pull), 0);
        cyc(2);

        // R2: arm during an unarmed event
        arm_clr = 1'b1; cyc(1); arm_clr = 1'b0;
        supply_low = 1'b1;
        cyc(4);
        arm_set = 1'b1; cyc(1); arm_set = 1'b0;
        check("R2 armed set mid-event", int'(armed), 1);
        seen = 0;
        for (int i = 0; i < 12; i++) begin cyc(1); if (host_inhibit) seen++; end
        check("R2 no save in unarmed event", seen, 0);
        supply_low = 1'b0;
        cyc(4);
        supply_low = 1'b1;
        seen = 0;
        for (int i = 0; i < BUDGET + 6; i++) begin cyc(1); if (host_inhibit) seen++; end
        check("R7 new event saves after release", seen, BUDGET);
        supply_low = 1'b0;
        cyc(4);

        // R8 set and clear together
        arm_set = 1'b1; arm_clr = 1'b1; cyc(1);
        arm_set = 1'b0; arm_clr = 1'b0;
        check("R8 clear wins", int'(armed), 0);

        // R9 brownout
        arm_set = 1'b1; cyc(1); arm_set = 1'b0;
        brownout = 1'b1; cyc(1);
        check("R9 brownout clears", int'(armed), 0);
        arm_set = 1'b1; cyc(1); arm_set = 1'b0;
        check("R9 set ignored in brownout", int'(armed), 0);
        brownout = 1'b0; cyc(2);
        check("R9 stays clear after recovery", int'(armed), 0);
        supply_low = 1'b1;
        seen = 0;
        for (int i = 0; i < 10; i++) begin cyc(1); if (host_inhibit) seen++; end
        check("R9 no save after brownout", seen, 0);
        supply_low = 1'b0;
        cyc(4);

        // R11 done while idle
        arm_set = 1'b1; cyc(1); arm_set = 1'b0;
        store_done = 1'b1; cyc(1); store_done = 1'b0;
        seen = 0;
        for (int i = 0; i < 3; i++) begin if (save_end || host_inhibit) seen++; cyc(1); end
        check("R11 idle done ignored", seen, 0);

        summary();
    end

endmodule